// File: doc/BRIEF.md
# Banked Data Memory Address Generator

This block forms the 12-bit effective data address used by byte-oriented and bit-oriented operations in a small 8-bit controller core. It reads the 16-bit instruction word and takes two things from it: an 8-bit file operand and an access bit. It combines them with a 4-bit bank register and a 16-bit pointer register, and from that it picks one of three addressing modes. In the banked direct mode the bank register supplies the upper four address bits. The forced mode maps the operand onto a fixed window. The indexed mode adds the operand, as an unsigned literal offset, to the pointer.

The data space is 4 KB, arranged as 16 banks of 256 bytes. Special function registers sit at the top of the last bank. An extension-enable input turns the indexed mode on or off. When the extension is off, an access bit of zero always gives the classic split window: low operands reach the bottom of bank 0 and high operands reach the top of bank 15. The bank and pointer registers live inside the block and have clocked write ports. The address output is combinational from the current register values, so a write shows up in the address starting with the cycle after the write edge.

Top module: `dm_addr_gen`

## Requirements
- R1: After reset, both the bank register and the pointer register read as zero. With the access bit at 1 the address equals the operand, and with the extension on and a low operand the indexed address also equals the operand.
- R2: When instruction bit 8 (access bit) is 1, the mode output is 2'b00 (banked) and the address is {bank[3:0], instr[7:0]}, whatever the operand value or the extension enable.
- R3: When the access bit is 0, the extension is on and the operand is 8'h60 or more, the mode output is 2'b01 (forced) and the address is 12'hF00 + operand, which covers F60h to FFFh.
- R4: When the access bit is 0, the extension is on and the operand is 8'h5F or less, the mode output is 2'b10 (indexed) and the address is pointer[11:0] + operand, with the operand zero-extended. Pointer bits 15..12 have no effect.
- R5: The indexed sum drops any carry out of bit 11, so it wraps within the 4 KB space (for example, pointer 12'hFF0 plus 8'h20 gives 12'h010).
- R6: With the extension off and the access bit 0, an operand of 8'h5F or less gives address 12'h000 + operand and mode 2'b01.
- R7: With the extension off and the access bit 0, an operand of 8'h60 or more gives address 12'hF00 + operand and mode 2'b01.
- R8: A write enable that is high at a rising clock edge loads the bank register or the pointer register from its write data. With the enable low, the register keeps its value whatever the write data does. The change is visible in the address from the cycle after the edge.
- R9: Instruction bits 15..9, including the destination bit at bit 9, have no effect on the address or the mode. Mode code 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; clears the bank and pointer registers |
| ext_en | input | 1 | Enables the indexed literal offset mode |
| instr | input | 16 | Instruction word; bit 8 is the access bit, bits 7..0 are the file operand |
| bank_we | input | 1 | Bank register write enable |
| bank_wdata | input | 4 | Bank register write data |
| ptr_we | input | 1 | Pointer register write enable |
| ptr_wdata | input | 16 | Pointer register write data |
| eff_addr | output | 12 | Effective data memory address |
| mode | output | 2 | Selected mode: 00 banked, 01 forced, 10 indexed |

## Verification
Random instruction words cover every mix of access bit, extension enable and operand value. The random bank and pointer writes between them show that the register values feed the address only from the cycle after the write. Directed cases put the operand at 5Fh and 60h in both extension settings, and these tell the indexed mode apart from the forced mode at the exact split point. Pointers near FFFh and pointers with their upper nibble set separate a correct 12-bit wrap from a sum that carries or that uses all 16 pointer bits. Changing only the destination bit, and changing only the write data while the write enable is low, shows that neither input leaks into the address.

// File: rtl/dm_addr_gen_pkg.sv
package dm_addr_gen_pkg;

    localparam int unsigned BANK_W  = 4;
    localparam int unsigned OFF_W   = 8;
    localparam int unsigned PTR_W   = 16;
    localparam int unsigned INSTR_W = 16;
    localparam int unsigned ADDR_W  = BANK_W + OFF_W;

    typedef enum logic [1:0] {
        MODE_BANKED  = 2'b00,
        MODE_FORCED  = 2'b01,
        MODE_INDEXED = 2'b10
    } addr_mode_e;

endpackage

// File: rtl/bank_ptr_regs.sv
module bank_ptr_regs #(
    parameter int unsigned BANK_W = 4,
    parameter int unsigned PTR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_we,
    input  logic [BANK_W-1:0] bank_wdata,
    input  logic              ptr_we,
    input  logic [PTR_W-1:0]  ptr_wdata,
    output logic [BANK_W-1:0] bank_q,
    output logic [PTR_W-1:0]  ptr_q
);

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [PTR_W-1:0]  ptr;
    } regs_t;

    regs_t regs_d;
    regs_t regs_q;

    always_comb begin
        regs_d = regs_q;
        if (bank_we) begin
            regs_d.bank = bank_wdata;
        end
        if (ptr_we) begin
            regs_d.ptr = ptr_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign bank_q = regs_q.bank;
    assign ptr_q  = regs_q.ptr;

endmodule

// File: rtl/operand_decoder.sv
module operand_decoder
    import dm_addr_gen_pkg::*;
#(
    parameter int unsigned INSTR_W     = 16,
    parameter int unsigned OFF_W       = 8,
    parameter int unsigned ACC_BIT     = 8,
    parameter int unsigned SPLIT_POINT = 8'h60
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic               ext_en,
    output logic [OFF_W-1:0]   operand,
    output addr_mode_e         sel_mode
);

    localparam logic [OFF_W-1:0] SPLIT = OFF_W'(SPLIT_POINT);

    logic access_bit;
    logic low_operand;

    always_comb begin
        operand     = instr[OFF_W-1:0];
        access_bit  = instr[ACC_BIT];
        low_operand = (operand < SPLIT);
        if (access_bit) begin
            sel_mode = MODE_BANKED;
        end else if (ext_en && low_operand) begin
            sel_mode = MODE_INDEXED;
        end else begin
            sel_mode = MODE_FORCED;
        end
    end

endmodule

// File: rtl/ea_compute.sv
module ea_compute
    import dm_addr_gen_pkg::*;
#(
    parameter int unsigned BANK_W      = 4,
    parameter int unsigned OFF_W       = 8,
    parameter int unsigned PTR_W       = 16,
    parameter int unsigned SPLIT_POINT = 8'h60
) (
    input  addr_mode_e                sel_mode,
    input  logic [OFF_W-1:0]          operand,
    input  logic [BANK_W-1:0]         bank,
    input  logic [PTR_W-1:0]          ptr,
    output logic [BANK_W+OFF_W-1:0]   addr
);

    localparam int unsigned AW = BANK_W + OFF_W;
    localparam logic [OFF_W-1:0]  SPLIT    = OFF_W'(SPLIT_POINT);
    localparam logic [BANK_W-1:0] TOP_BANK = '1;
    localparam logic [BANK_W-1:0] BOT_BANK = '0;

    logic [AW-1:0] idx_sum;
    logic [AW-1:0] forced_addr;

    always_comb begin
        idx_sum     = ptr[AW-1:0] + {{BANK_W{1'b0}}, operand};
        forced_addr = (operand < SPLIT) ? {BOT_BANK, operand} : {TOP_BANK, operand};
        unique case (sel_mode)
            MODE_BANKED:  addr = {bank, operand};
            MODE_INDEXED: addr = idx_sum;
            default:      addr = forced_addr;
        endcase
    end

endmodule

// File: rtl/dm_addr_gen.sv
module dm_addr_gen
    import dm_addr_gen_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ext_en,
    input  logic [INSTR_W-1:0]  instr,
    input  logic                bank_we,
    input  logic [BANK_W-1:0]   bank_wdata,
    input  logic                ptr_we,
    input  logic [PTR_W-1:0]    ptr_wdata,
    output logic [ADDR_W-1:0]   eff_addr,
    output logic [1:0]          mode
);

    localparam int unsigned ACC_BIT     = OFF_W;
    localparam int unsigned SPLIT_POINT = 8'h60;

    logic [BANK_W-1:0] bank_q;
    logic [PTR_W-1:0]  ptr_q;
    logic [OFF_W-1:0]  operand;
    addr_mode_e        sel_mode;

    bank_ptr_regs #(
        .BANK_W (BANK_W),
        .PTR_W  (PTR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bank_we    (bank_we),
        .bank_wdata (bank_wdata),
        .ptr_we     (ptr_we),
        .ptr_wdata  (ptr_wdata),
        .bank_q     (bank_q),
        .ptr_q      (ptr_q)
    );

    operand_decoder #(
        .INSTR_W     (INSTR_W),
        .OFF_W       (OFF_W),
        .ACC_BIT     (ACC_BIT),
        .SPLIT_POINT (SPLIT_POINT)
    ) u_dec (
        .instr    (instr),
        .ext_en   (ext_en),
        .operand  (operand),
        .sel_mode (sel_mode)
    );

    ea_compute #(
        .BANK_W      (BANK_W),
        .OFF_W       (OFF_W),
        .PTR_W       (PTR_W),
        .SPLIT_POINT (SPLIT_POINT)
    ) u_ea (
        .sel_mode (sel_mode),
        .operand  (operand),
        .bank     (bank_q),
        .ptr      (ptr_q),
        .addr     (eff_addr)
    );

    assign mode = sel_mode;

endmodule

// File: rtl/dm_addr_gen_chk.sv
module dm_addr_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ext_en,
    input logic [15:0] instr,
    input logic        bank_we,
    input logic [3:0]  bank_wdata,
    input logic        ptr_we,
    input logic [15:0] ptr_wdata,
    input logic [11:0] eff_addr,
    input logic [1:0]  mode,
    input logic [3:0]  bank_q,
    input logic [15:0] ptr_q
);

    AST_BANKED_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        instr[8] |-> (mode == 2'b00) && (eff_addr == {bank_q, instr[7:0]})); // R2

    AST_FORCED_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr[8] && instr[7:0] >= 8'h60) |-> (mode == 2'b01) && (eff_addr == {4'hF, instr[7:0]})); // R3

    AST_INDEXED_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr[8] && ext_en && instr[7:0] < 8'h60) |->
            (mode == 2'b10) && (eff_addr == 12'(ptr_q[11:0] + {4'h0, instr[7:0]}))); // R4

    AST_LEGACY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr[8] && !ext_en && instr[7:0] < 8'h60) |-> (mode == 2'b01) && (eff_addr == {4'h0, instr[7:0]})); // R6

    AST_NO_MODE3: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'b11); // R9

    AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |=> bank_q == $past(bank_wdata)); // R8

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_we |=> $stable(bank_q)); // R8

    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_we |=> ptr_q == $past(ptr_wdata)); // R8

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_we |=> $stable(ptr_q)); // R8

endmodule

bind dm_addr_gen dm_addr_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_en     (ext_en),
    .instr      (instr),
    .bank_we    (bank_we),
    .bank_wdata (bank_wdata),
    .ptr_we     (ptr_we),
    .ptr_wdata  (ptr_wdata),
    .eff_addr   (eff_addr),
    .mode       (mode),
    .bank_q     (bank_q),
    .ptr_q      (ptr_q)
);

// File: tb/dm_addr_gen_test.sv
module dm_addr_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_en = 1'b0;
    logic [15:0] instr = '0;
    logic        bank_we = 1'b0;
    logic [3:0]  bank_wdata = '0;
    logic        ptr_we = 1'b0;
    logic [15:0] ptr_wdata = '0;
    logic [11:0] eff_addr;
    logic [1:0]  mode;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [3:0]  m_bank = '0;
    logic [15:0] m_ptr  = '0;

    always #10 clk = ~clk;

    dm_addr_gen uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_en     (ext_en),
        .instr      (instr),
        .bank_we    (bank_we),
        .bank_wdata (bank_wdata),
        .ptr_we     (ptr_we),
        .ptr_wdata  (ptr_wdata),
        .eff_addr   (eff_addr),
        .mode       (mode)
    );

    function automatic logic [1:0] exp_mode(input logic en, input logic [15:0] ins);
        if (ins[8]) return 2'b00;
        if (en && ins[7:0] < 8'h60) return 2'b10;
        return 2'b01;
    endfunction

    function automatic logic [11:0] exp_addr(input logic en, input logic [15:0] ins,
                                             input logic [3:0] b, input logic [15:0] p);
        logic [12:0] wide;
        if (ins[8]) return {b, ins[7:0]};
        if (ins[7:0] >= 8'h60) return 12'hF00 | {4'h0, ins[7:0]};
        if (!en) return {4'h0, ins[7:0]};
        wide = {1'b0, p[11:0]} + {5'h0, ins[7:0]};
        return wide[11:0];
    endfunction

    task automatic check(input string req);
        logic [11:0] ea;
        logic [1:0]  em;
        ea = exp_addr(ext_en, instr, m_bank, m_ptr);
        em = exp_mode(ext_en, instr);
        checks++;
        if (eff_addr !== ea || mode !== em) begin
            errors++;
            $display("FAIL %s: instr=%h ext=%0b addr=%h mode=%b expected addr=%h mode=%b",
                     req, instr, ext_en, eff_addr, mode, ea, em);
        end
    endtask

    // drive at negedge, sample a little later, then let the posedge apply writes
    task automatic step(input string req, input logic en, input logic [15:0] ins,
                        input logic bwe, input logic [3:0] bwd,
                        input logic pwe, input logic [15:0] pwd);
        @(negedge clk);
        ext_en = en; instr = ins;
        bank_we = bwe; bank_wdata = bwd;
        ptr_we = pwe; ptr_wdata = pwd;
        #2;
        check(req);
        @(posedge clk);
        if (bwe) m_bank = bwd;
        if (pwe) m_ptr = pwd;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        step("R1", 1'b0, 16'h2155, 1'b0, 4'h0, 1'b0, 16'h0);
        step("R1", 1'b1, 16'h2033, 1'b0, 4'h0, 1'b0, 16'h0);

        // R2 banked with bank writes, R8 visible next cycle
        step("R8", 1'b1, 16'h2100, 1'b1, 4'h7, 1'b0, 16'h0);
        step("R2", 1'b1, 16'h21A5, 1'b0, 4'h3, 1'b0, 16'h0);
        step("R2", 1'b0, 16'h2112, 1'b0, 4'h9, 1'b0, 16'h0);

        // R3 split boundary with extension on
        step("R3", 1'b1, 16'h2060, 1'b0, 4'h0, 1'b0, 16'h0);
        step("R3", 1'b1, 16'h20FF, 1'b0, 4'h0, 1'b0, 16'h0);

        // R4 indexed, pointer upper nibble set
        step("R8", 1'b1, 16'h205F, 1'b0, 4'h0, 1'b1, 16'hA123);
        step("R4", 1'b1, 16'h205F, 1'b0, 4'h0, 1'b0, 16'h0);
        step("R4", 1'b1, 16'h2000, 1'b0, 4'h0, 1'b0, 16'hFFFF);

        // R5 wrap
        step("R8", 1'b1, 16'h2000, 1'b0, 4'h0, 1'b1, 16'h0FF0);
        step("R5", 1'b1, 16'h2020, 1'b0, 4'h0, 1'b0, 16'h0);
        step("R8", 1'b1, 16'h2000, 1'b0, 4'h0, 1'b1, 16'h5FFF);
        step("R5", 1'b1, 16'h205F, 1'b0, 4'h0, 1'b0, 16'h0);

        // R6 / R7 extension off
        step("R6", 1'b0, 16'h205F, 1'b0, 4'h0, 1'b0, 16'h0);
        step("R6", 1'b0, 16'h2000, 1'b0, 4'h0, 1'b0, 16'h0);
        step("R7", 1'b0, 16'h2060, 1'b0, 4'h0, 1'b0, 16'h0);
        step("R7", 1'b0, 16'h20C4, 1'b0, 4'h0, 1'b0, 16'h0);

        // R9 upper instruction bits and destination bit ignored
        step("R9", 1'b1, 16'h0240, 1'b0, 4'h0, 1'b0, 16'h0);
        step("R9", 1'b1, 16'hFE40, 1'b0, 4'h0, 1'b0, 16'h0);
        step("R9", 1'b1, 16'h2340, 1'b0, 4'h0, 1'b0, 16'h0);

        // R8 write data changing with enables low has no effect
        step("R8", 1'b1, 16'h2110, 1'b0, 4'hE, 1'b0, 16'h0777);
        step("R8", 1'b1, 16'h2010, 1'b0, 4'h1, 1'b0, 16'h0123);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom();
            step("R2-R9 random", r[0], $urandom() & 32'hFFFF,
                 (r[3:1] == 3'd0), r[7:4], (r[10:8] == 3'd0), r[31:16]);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule